// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block builds a memory operand address from up to three parts. The parts are an optional base register value, an optional index register value multiplied by 1, 2, 4 or 8, and a displacement that arrives as an 8-, 16- or 32-bit field. A segment base is then added to the effective address, which gives the linear address. Leaving terms out gives every addressing form: displacement only, base only, base plus displacement, scaled index plus displacement, base plus index, and base plus scaled index with or without a displacement.

The register file supplies the base value and the index value. The decoder supplies the valid flags, the index register number, the scale code and the displacement size code. The stack pointer may not serve as the index. When the decoder names it as the index, the block drops the index term and raises an error flag. By default the results are registered and appear one clock after the inputs. A parameter selects a purely combinational variant instead. Every sum is taken modulo 2^ADDR_W and any carry out is dropped.

Top module: `seg_ea_gen`

## Requirements
- R1: `ea_out` equals base term + index term + displacement term modulo 2^32, and any carry out of the top bit is dropped.
- R2: The scale code multiplies the index value: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x8. Bits shifted past bit 31 are lost.
- R3: With `disp_size` = 01, the displacement term is `disp_in[7:0]` sign-extended to 32 bits, and `disp_in[31:8]` has no effect.
- R4: With `disp_size` = 10, the displacement term is `disp_in[15:0]` sign-extended to 32 bits, and `disp_in[31:16]` has no effect.
- R5: With `disp_size` = 11, the displacement term is the whole of `disp_in`.
- R6: With `disp_size` = 00, the displacement term is zero whatever `disp_in` holds.
- R7: With `base_valid` = 0, the base term is zero and `base_val` has no effect.
- R8: With `index_valid` = 0, the index term is zero and `idx_err` stays 0 for any `index_reg`, including 4.
- R9: With `index_valid` = 1 and `index_reg` = 4 (the stack pointer), `idx_err` is 1 and the index term is zero. The base and displacement terms still count.
- R10: `lin_addr` equals `seg_base` + `ea_out` modulo 2^32.
- R11: In the default registered variant, outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register and the checks |
| rst_n | input | 1 | Active-low synchronous reset |
| base_valid | input | 1 | Base term is present |
| base_val | input | 32 | Base register value |
| index_valid | input | 1 | Index term is present |
| index_reg | input | 3 | Index register number (4 = stack pointer, illegal) |
| index_val | input | 32 | Index register value |
| scale_code | input | 2 | Index shift amount: 00 x1, 01 x2, 10 x4, 11 x8 |
| disp_in | input | 32 | Displacement field, right-aligned |
| disp_size | input | 2 | Displacement size: 00 none, 01 8-bit, 10 16-bit, 11 32-bit |
| seg_base | input | 32 | Segment base address |
| ea_out | output | 32 | Effective address |
| lin_addr | output | 32 | Linear address |
| idx_err | output | 1 | Stack pointer was named as the index |

## Verification
The assertions are evaluated on every cycle, so the following hold for whatever inputs arrive:
- the sign-extension shape of the 8- and 16-bit displacement;
- the suppression of the index term on an error or an absent index;
- the shift relation between index value and scaled term;
- the one-cycle relation of `lin_addr`, `ea_out` and `idx_err` to the registered terms and the sampled segment base.

Only the bench's scenarios can show that the complete sum matches the intended arithmetic for each addressing form. The same goes for the wrap-around at 2^32 and for the rule that the unused upper displacement bits and the values of absent registers have no effect at the ports.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [1:0] {
      DSZ_NONE = 2'b00,
      DSZ_B8   = 2'b01,
      DSZ_B16  = 2'b10,
      DSZ_FULL = 2'b11
   } disp_size_e;

   typedef enum logic [1:0] {
      SC_X1 = 2'b00,
      SC_X2 = 2'b01,
      SC_X4 = 2'b10,
      SC_X8 = 2'b11
   } scale_e;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] disp_in,
   input  logic [1:0]        disp_size,
   output logic [ADDR_W-1:0] disp_term
);
   localparam int HI8  = ADDR_W - 8;
   localparam int HI16 = ADDR_W - 16;

   disp_size_e sz;
   assign sz = disp_size_e'(disp_size);

   always_comb begin
      unique case (sz)
         DSZ_NONE: disp_term = '0;
         DSZ_B8:   disp_term = {{HI8{disp_in[7]}}, disp_in[7:0]};
         DSZ_B16:  disp_term = {{HI16{disp_in[15]}}, disp_in[15:0]};
         default:  disp_term = disp_in;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst_n) begin
         // R3: upper bits replicate bit 7 of the short displacement
         if (sz == DSZ_B8)
            assert_sext8_R3: assert ($countones(disp_term[ADDR_W-1:7]) == 0 ||
                                     $countones(disp_term[ADDR_W-1:7]) == HI8 + 1);
         // R4: upper bits replicate bit 15
         if (sz == DSZ_B16)
            assert_sext16_R4: assert ($countones(disp_term[ADDR_W-1:15]) == 0 ||
                                      $countones(disp_term[ADDR_W-1:15]) == HI16 + 1);
         // R6: absent displacement contributes nothing
         if (sz == DSZ_NONE)
            assert_no_disp_R6: assert (disp_term == '0);
      end
   end
endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler
   import agu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_W  = 3,
   parameter int SP_NUM = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              index_valid,
   input  logic [REG_W-1:0]  index_reg,
   input  logic [ADDR_W-1:0] index_val,
   input  logic [1:0]        scale_code,
   output logic [ADDR_W-1:0] index_term,
   output logic              index_bad
);
   localparam logic [REG_W-1:0] SP_CODE = REG_W'(SP_NUM);

   logic              use_index;
   logic [ADDR_W-1:0] shifted;

   assign index_bad = index_valid && (index_reg == SP_CODE);
   assign use_index = index_valid && !index_bad;

   always_comb begin
      unique case (scale_e'(scale_code))
         SC_X1:   shifted = index_val;
         SC_X2:   shifted = {index_val[ADDR_W-2:0], 1'b0};
         SC_X4:   shifted = {index_val[ADDR_W-3:0], 2'b00};
         default: shifted = {index_val[ADDR_W-4:0], 3'b000};
      endcase
   end

   assign index_term = use_index ? shifted : '0;

   always_ff @(posedge clk) begin
      if (rst_n) begin
         // R8, R9: no index term when absent or illegal
         if (!index_valid || index_bad)
            assert_idx_zero_R9: assert (index_term == '0);
         // R2: undoing the shift recovers the surviving index bits
         if (use_index)
            assert_scale_R2: assert ((index_term >> scale_code) ==
                                     (index_val & ({ADDR_W{1'b1}} >> scale_code)));
         // R8: an absent index never flags an error
         if (!index_valid)
            assert_no_err_R8: assert (!index_bad);
      end
   end
endmodule

// File: rtl/agu_sum_stage.sv
module agu_sum_stage #(
   parameter int ADDR_W     = 32,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_term,
   input  logic [ADDR_W-1:0] index_term,
   input  logic [ADDR_W-1:0] disp_term,
   input  logic [ADDR_W-1:0] seg_base,
   input  logic              index_bad,
   output logic [ADDR_W-1:0] ea_out,
   output logic [ADDR_W-1:0] lin_addr,
   output logic              idx_err
);
   logic [ADDR_W-1:0] ea_c;
   logic [ADDR_W-1:0] lin_c;

   // carries out of the top bit fall off by width truncation
   assign ea_c  = base_term + index_term + disp_term;
   assign lin_c = seg_base + ea_c;

   generate
      if (REGISTERED) begin : g_reg
         logic [ADDR_W-1:0] ea_q;
         logic [ADDR_W-1:0] lin_q;
         logic              err_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ea_q  <= '0;
               lin_q <= '0;
               err_q <= 1'b0;
            end else begin
               ea_q  <= ea_c;
               lin_q <= lin_c;
               err_q <= index_bad;
            end
         end

         assign ea_out   = ea_q;
         assign lin_addr = lin_q;
         assign idx_err  = err_q;

         // R1: registered EA is the sum of last cycle's terms
         assert_ea_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> ea_out == $past(base_term + index_term + disp_term));
         // R10: linear address follows sampled segment base plus EA
         assert_lin_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> lin_addr == $past(seg_base) + ea_out);
         // R9: error output follows the illegal-index detection by one cycle
         assert_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
            index_bad |=> idx_err);
         // R11: after a reset cycle the outputs are clear
         assert_reset_R11: assert property (@(posedge clk)
            !rst_n |=> (ea_out == '0 && lin_addr == '0 && !idx_err));
      end else begin : g_comb
         assign ea_out   = ea_c;
         assign lin_addr = lin_c;
         assign idx_err  = index_bad;
      end
   endgenerate
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
   parameter int ADDR_W     = 32,
   parameter int REG_W      = 3,
   parameter int SP_NUM     = 4,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_valid,
   input  logic [ADDR_W-1:0] base_val,
   input  logic              index_valid,
   input  logic [REG_W-1:0]  index_reg,
   input  logic [ADDR_W-1:0] index_val,
   input  logic [1:0]        scale_code,
   input  logic [ADDR_W-1:0] disp_in,
   input  logic [1:0]        disp_size,
   input  logic [ADDR_W-1:0] seg_base,
   output logic [ADDR_W-1:0] ea_out,
   output logic [ADDR_W-1:0] lin_addr,
   output logic              idx_err
);
   localparam int NUM_REGS = 1 << REG_W;

   generate
      if (ADDR_W < 16) begin : g_bad_width
         $error("ADDR_W must be at least 16 to hold a 16-bit displacement");
      end
      if (SP_NUM < 0 || SP_NUM >= NUM_REGS) begin : g_bad_sp
         $error("SP_NUM must name a register inside the register file");
      end
   endgenerate

   logic [ADDR_W-1:0] base_term;
   logic [ADDR_W-1:0] index_term;
   logic [ADDR_W-1:0] disp_term;
   logic              index_bad;

   // the base may be any register, the stack pointer included
   assign base_term = base_valid ? base_val : '0;

   agu_disp_ext #(.ADDR_W(ADDR_W)) disp_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .disp_in   (disp_in),
      .disp_size (disp_size),
      .disp_term (disp_term)
   );

   agu_index_scaler #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SP_NUM(SP_NUM)) idx_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .index_valid (index_valid),
      .index_reg   (index_reg),
      .index_val   (index_val),
      .scale_code  (scale_code),
      .index_term  (index_term),
      .index_bad   (index_bad)
   );

   agu_sum_stage #(.ADDR_W(ADDR_W), .REGISTERED(REGISTERED)) sum_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .base_term  (base_term),
      .index_term (index_term),
      .disp_term  (disp_term),
      .seg_base   (seg_base),
      .index_bad  (index_bad),
      .ea_out     (ea_out),
      .lin_addr   (lin_addr),
      .idx_err    (idx_err)
   );
endmodule

// File: tb/seg_ea_gen_tb_top.sv
`timescale 1ns/1ps
module seg_ea_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        base_valid = 1'b0;
   logic [31:0] base_val = '0;
   logic        index_valid = 1'b0;
   logic [2:0]  index_reg = '0;
   logic [31:0] index_val = '0;
   logic [1:0]  scale_code = '0;
   logic [31:0] disp_in = '0;
   logic [1:0]  disp_size = '0;
   logic [31:0] seg_base = '0;
   logic [31:0] ea_out;
   logic [31:0] lin_addr;
   logic        idx_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   seg_ea_gen dut_i (
      .clk(clk), .rst_n(rst_n),
      .base_valid(base_valid), .base_val(base_val),
      .index_valid(index_valid), .index_reg(index_reg), .index_val(index_val),
      .scale_code(scale_code), .disp_in(disp_in), .disp_size(disp_size),
      .seg_base(seg_base), .ea_out(ea_out), .lin_addr(lin_addr), .idx_err(idx_err)
   );

   function automatic logic [31:0] model_disp(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'b00:   return 32'd0;
         2'b01:   return {{24{d[7]}}, d[7:0]};
         2'b10:   return {{16{d[15]}}, d[15:0]};
         default: return d;
      endcase
   endfunction

   function automatic logic [31:0] model_ea();
      logic [31:0] b;
      logic [31:0] i;
      b = base_valid ? base_val : 32'd0;
      i = (index_valid && index_reg != 3'd4) ? index_val * (32'd1 << scale_code) : 32'd0;
      return b + i + model_disp(disp_in, disp_size);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // apply current inputs, wait for the capturing edge, then compare
   task automatic run_vec(input string req);
      logic [31:0] e_ea;
      logic [31:0] e_lin;
      logic        e_err;
      e_ea  = model_ea();
      e_lin = seg_base + e_ea;
      e_err = index_valid && index_reg == 3'd4;
      @(posedge clk);
      #2;
      check({req, " ea"}, ea_out, e_ea);
      check({req, " lin"}, lin_addr, e_lin);
      check({req, " err"}, {31'd0, idx_err}, {31'd0, e_err});
      @(negedge clk);
   endtask

   task automatic set_vec(input logic bv, input logic [31:0] b, input logic iv,
                          input logic [2:0] ir, input logic [31:0] i, input logic [1:0] sc,
                          input logic [31:0] d, input logic [1:0] ds, input logic [31:0] sg);
      base_valid = bv; base_val = b; index_valid = iv; index_reg = ir;
      index_val = i; scale_code = sc; disp_in = d; disp_size = ds; seg_base = sg;
   endtask

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      set_vec(1, 32'h1111_1111, 1, 3'd1, 32'h2222_2222, 2'd3, 32'h7777_7777, 2'd3, 32'h5555_5555);
      repeat (3) @(posedge clk);
      #2;
      // R11: reset holds outputs at zero
      check("R11 reset ea", ea_out, 32'd0);
      check("R11 reset lin", lin_addr, 32'd0);
      check("R11 reset err", {31'd0, idx_err}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5: displacement only, full width
      set_vec(0, 32'hDEAD_BEEF, 0, 3'd4, 32'hCAFE_F00D, 2'd2, 32'h0001_2340, 2'd3, 32'h0010_0000);
      run_vec("R5 R7 R8 disp32 only");
      // R3: 8-bit negative, upper bits junk
      set_vec(0, 32'h0, 0, 3'd0, 32'h0, 2'd0, 32'hABCD_EF80, 2'd1, 32'h0);
      run_vec("R3 disp8 neg");
      set_vec(1, 32'h0000_1000, 0, 3'd0, 32'h0, 2'd0, 32'hFFFF_FF7F, 2'd1, 32'h0);
      run_vec("R3 disp8 pos");
      // R4: 16-bit negative and positive
      set_vec(1, 32'h0000_1000, 0, 3'd0, 32'h0, 2'd0, 32'h1234_8000, 2'd2, 32'h0);
      run_vec("R4 disp16 neg");
      set_vec(1, 32'h0000_1000, 0, 3'd0, 32'h0, 2'd0, 32'hFFFF_7FFF, 2'd2, 32'h0);
      run_vec("R4 disp16 pos");
      // R6: no displacement, base only
      set_vec(1, 32'h0040_0000, 0, 3'd0, 32'h0, 2'd0, 32'hFFFF_FFFF, 2'd0, 32'h0);
      run_vec("R6 base only");
      // R2: each scale with an index of 3
      for (int s = 0; s < 4; s++) begin
         set_vec(0, 32'h0, 1, 3'd6, 32'h3, 2'(s), 32'h100, 2'd3, 32'h0);
         run_vec("R2 scale");
      end
      // R2: shifted-out bits lost
      set_vec(0, 32'h0, 1, 3'd7, 32'hF000_0001, 2'd3, 32'h0, 2'd0, 32'h0);
      run_vec("R2 scale overflow");
      // R9: stack pointer as index, base may be register 4 too
      set_vec(1, 32'h0000_8000, 1, 3'd4, 32'h1234_5678, 2'd2, 32'h10, 2'd1, 32'h2000_0000);
      run_vec("R9 sp index");
      // R8: register 4 named but index absent
      set_vec(1, 32'h0000_8000, 0, 3'd4, 32'h1234_5678, 2'd2, 32'h10, 2'd1, 32'h0);
      run_vec("R8 absent sp");
      // R1: carry dropped
      set_vec(1, 32'hFFFF_FFFF, 1, 3'd2, 32'h8000_0000, 2'd1, 32'h0000_0002, 2'd3, 32'h0);
      run_vec("R1 wrap");
      // R10: segment add wraps
      set_vec(1, 32'h9000_0000, 0, 3'd0, 32'h0, 2'd0, 32'h0, 2'd0, 32'h8000_0010);
      run_vec("R10 seg wrap");
      // R1: base plus index, no displacement
      set_vec(1, 32'h0000_0100, 1, 3'd3, 32'h0000_0020, 2'd0, 32'h5A5A_5A5A, 2'd0, 32'h0);
      run_vec("R1 base+index");

      // R1 R10: random mix
      for (int n = 0; n < 400; n++) begin
         set_vec(1'($urandom), $urandom, 1'($urandom), 3'($urandom), $urandom,
                 2'($urandom), $urandom, 2'($urandom), $urandom);
         run_vec("R1 R10 random");
      end

      // R11: reset again clears outputs
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      check("R11 rereset ea", ea_out, 32'd0);
      check("R11 rereset lin", lin_addr, 32'd0);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule